// File: doc/BRIEF.md
# VCO Gain Code Calibration Controller

This block chooses the 4-bit gain setting for a ring-oscillator VCO while the surrounding PLL stays locked in closed loop. A start pulse places the code at its top value (4'hF) and turns on the fastlock output. The block then lowers the code by one level at a time. After each change it waits a programmable number of reference-clock cycles so the loop can settle, and then it reads a single comparator bit. That bit is high when the loop control voltage is above a fixed reference.

The search stops at the first code for which the comparator reads high. If the code reaches zero and the comparator is still low, the block keeps zero and raises a saturation flag. Once the final code is latched, fastlock drops one cycle later and done rises. The code then holds until the next start pulse.

The comparator arrives asynchronously and passes through a two-flop synchronizer. Its value is therefore seen two cycles late. Software or a sequencer should set the settle count to at least 2, so that the value sampled reflects the current code.

The controller has three states:
- ST_IDLE waits for start. Start moves it to ST_SETTLE.
- ST_SETTLE stays put while the settle timer runs. When the timer expires there are three cases:
  - The comparator is low and the code is not zero: the code steps down, the timer reloads and the state stays in ST_SETTLE.
  - The comparator is high: the state moves to ST_RELEASE.
  - The comparator is low at code zero: the state moves to ST_RELEASE with saturation set.
- ST_RELEASE always returns to ST_IDLE after one cycle.

Top module: `vco_gain_cal`

## Requirements
- R1: While reset is held and after it is released, gain_code_o is 4'hF and fastlock_o, done_o and sat_o are all 0.
- R2: A start_i pulse seen in the idle state makes gain_code_o 4'hF, fastlock_o 1, done_o 0 and sat_o 0 on the next cycle. fastlock_o then stays 1 until the search ends.
- R3: During a search, gain_code_o changes only by decreasing by exactly one. It never goes below 0.
- R4: Each code is held for settle_cycles_i+1 cycles. The comparator value used at the end of that window is cmp_async_i as sampled two clock edges earlier (two-flop synchronizer).
- R5: If the sampled comparator is 0 at code 0, the code stays 0 and sat_o becomes 1.
- R6: When the sampled comparator is 1, the code is kept. On the following cycle fastlock_o falls and done_o rises together, and the two are never 1 at the same time.
- R7: start_i pulses while a search is running have no effect.
- R8: After a search ends, gain_code_o, done_o and sat_o hold their values until the next start_i. A new start clears done_o and sat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a calibration |
| settle_cycles_i | input | WAIT_W (8) | Extra cycles each code is held before the comparator is read |
| cmp_async_i | input | 1 | Asynchronous comparator: control voltage above reference |
| gain_code_o | output | CODE_W (4) | VCO gain code |
| fastlock_o | output | 1 | Fastlock request, high during calibration |
| done_o | output | 1 | Calibration finished |
| sat_o | output | 1 | Search reached code 0 without a comparator crossing |

## Verification
A wrong state or a wrong timer value shows up within one settle window: the code steps down one window too early or too late, or it keeps stepping after the comparator was already high. A wrong synchronizer depth moves the stop point by a code when the settle count is small. A corrupted exit path shows on the next edge as fastlock and done both high, or as a code that drifts while idle. Comparing every port on every cycle against an independent model therefore finds each of these faults within a few cycles of its cause.

// File: rtl/vcal_pkg.sv
package vcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_RELEASE = 2'd2
    } vcal_state_e;

endpackage

// File: rtl/vcal_sync2.sv
module vcal_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/vcal_settle_timer.sv
module vcal_settle_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] count_i,
    output logic              expired_o
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= count_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/vcal_fsm.sv
module vcal_fsm
    import vcal_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_sync_i,
    input  logic              expired_i,
    output logic              tmr_load_o,
    output logic [CODE_W-1:0] code_o,
    output logic              fastlock_o,
    output logic              done_o,
    output logic              sat_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    vcal_state_e state_q, state_d;
    logic at_floor, step_down, finish;

    assign at_floor  = (code_o == '0);
    // Sample point: timer expired while settling
    assign finish    = (state_q == ST_SETTLE) && expired_i && (cmp_sync_i || at_floor);
    assign step_down = (state_q == ST_SETTLE) && expired_i && !cmp_sync_i && !at_floor;
    assign tmr_load_o = ((state_q == ST_IDLE) && start_i) || step_down;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SETTLE;
            ST_SETTLE:  if (finish)  state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o     <= CODE_MAX;
            fastlock_o <= 1'b0;
            done_o     <= 1'b0;
            sat_o      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        code_o     <= CODE_MAX;
                        fastlock_o <= 1'b1;
                        done_o     <= 1'b0;
                        sat_o      <= 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (step_down)
                        code_o <= code_o - 1'b1;
                    else if (finish && !cmp_sync_i)
                        sat_o <= 1'b1;
                end
                ST_RELEASE: begin
                    fastlock_o <= 1'b0;
                    done_o     <= 1'b1;
                end
                default: fastlock_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vco_gain_cal.sv
module vco_gain_cal #(
    parameter int CODE_W = 4,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WAIT_W-1:0] settle_cycles_i,
    input  logic              cmp_async_i,
    output logic [CODE_W-1:0] gain_code_o,
    output logic              fastlock_o,
    output logic              done_o,
    output logic              sat_o
);
    logic cmp_sync, expired, tmr_load;

    vcal_sync2 #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_async_i),
        .sync_o  (cmp_sync)
    );

    vcal_settle_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .count_i   (settle_cycles_i),
        .expired_o (expired)
    );

    vcal_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_sync_i (cmp_sync),
        .expired_i  (expired),
        .tmr_load_o (tmr_load),
        .code_o     (gain_code_o),
        .fastlock_o (fastlock_o),
        .done_o     (done_o),
        .sat_o      (sat_o)
    );
endmodule

// File: rtl/vcal_checker.sv
module vcal_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CODE_W-1:0] gain_code_o,
    input logic              fastlock_o,
    input logic              done_o,
    input logic              sat_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    AST_FL_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fastlock_o && done_o)); // R6

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fastlock_o && $past(fastlock_o) && gain_code_o != $past(gain_code_o))
        |-> (gain_code_o + 1'b1) == $past(gain_code_o)); // R3

    AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> gain_code_o == '0); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fastlock_o && !$past(fastlock_o)) |-> ($stable(gain_code_o) && $stable(sat_o))); // R8

    AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fastlock_o) |-> (gain_code_o == CODE_MAX && !done_o && !sat_o)); // R2

    AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(fastlock_o)); // R6
endmodule

bind vco_gain_cal vcal_checker #(.CODE_W(CODE_W)) u_vcal_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .gain_code_o (gain_code_o),
    .fastlock_o  (fastlock_o),
    .done_o      (done_o),
    .sat_o       (sat_o)
);

// File: tb/vco_gain_cal_tb_top.sv
module vco_gain_cal_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] settle_cycles_i = 8'd0;
    logic       cmp_async_i = 1'b0;
    logic [3:0] gain_code_o;
    logic       fastlock_o, done_o, sat_o;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    vco_gain_cal dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .settle_cycles_i(settle_cycles_i), .cmp_async_i(cmp_async_i),
        .gain_code_o(gain_code_o), .fastlock_o(fastlock_o),
        .done_o(done_o), .sat_o(sat_o)
    );

    // Behavioural reference: phase 0 idle, 1 searching, 2 wrap-up
    int m_phase, m_code, m_fl, m_done, m_sat, m_cnt, m_s1, m_s2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_code = 15; m_fl = 0; m_done = 0; m_sat = 0;
            m_cnt = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            int seen;
            seen = m_s2;
            m_s2 = m_s1;
            m_s1 = int'(cmp_async_i);
            case (m_phase)
                0: if (start_i) begin
                       m_code = 15; m_fl = 1; m_done = 0; m_sat = 0;
                       m_cnt = int'(settle_cycles_i); m_phase = 1;
                   end
                1: if (m_cnt > 0) m_cnt--;
                   else if (seen == 1) m_phase = 2;
                   else if (m_code == 0) begin m_sat = 1; m_phase = 2; end
                   else begin m_code--; m_cnt = int'(settle_cycles_i); end
                default: begin m_fl = 0; m_done = 1; m_phase = 0; end
            endcase
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One cycle: compare all outputs at negedge, then drive new inputs
    task automatic step(bit st, int target);
        @(negedge clk);
        cyc++;
        chk("R3/R4 gain_code", int'(gain_code_o), m_code);
        chk("R2 fastlock",     int'(fastlock_o),  m_fl);
        chk("R6 done",         int'(done_o),      m_done);
        chk("R5 sat",          int'(sat_o),       m_sat);
        start_i     = st;
        cmp_async_i = (m_code <= target);
    endtask

    // Full calibration; target = highest code where comparator reads high
    task automatic run_cal(int settle, int target, bit poke_start);
        int guard;
        settle_cycles_i = 8'(settle);
        step(1'b1, target);
        step(1'b0, target);
        guard = 0;
        while (m_done == 0 && guard < 2000) begin
            step(poke_start && (guard % 7 == 3), target); // R7 stray starts
            guard++;
        end
        if (guard >= 2000) chk("R6 watchdog on done", 0, 1);
        step(1'b0, target);
    endtask

    initial begin
        repeat (3) step(1'b0, -1);
        chk("R1 reset code", int'(gain_code_o), 15);
        chk("R1 reset fastlock", int'(fastlock_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (2) step(1'b0, 20);
        chk("R1 idle sat", int'(sat_o), 0);

        run_cal(3, 9, 1'b0);
        chk("R6 stop code target 9", int'(gain_code_o), 9);
        chk("R5 no sat target 9", int'(sat_o), 0);

        repeat (5) step(1'b0, -1); // comparator toggles while idle
        chk("R8 hold code idle", int'(gain_code_o), 9);
        chk("R8 hold done idle", int'(done_o), 1);

        run_cal(2, -1, 1'b1);
        chk("R5 saturate code", int'(gain_code_o), 0);
        chk("R5 saturate flag", int'(sat_o), 1);

        run_cal(5, 15, 1'b0);
        chk("R2 top code kept", int'(gain_code_o), 15);
        chk("R8 start cleared sat", int'(sat_o), 0);

        run_cal(0, 6, 1'b1); // R4 synchronizer lag overshoots with zero settle
        chk("R4 zero-settle stop", int'(gain_code_o), m_code);

        run_cal(2, 0, 1'b1);
        chk("R3 reach code 0", int'(gain_code_o), 0);
        chk("R5 crossing at 0 no sat", int'(sat_o), 0);

        run_cal(7, 4, 1'b1);
        chk("R7 stray start stop", int'(gain_code_o), 4);

        repeat (3) step(1'b0, 20);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule